// File: doc/BRIEF.md
# Stereo Serial Audio Engine (I2S / Left-Justified)

This block moves 16-bit stereo audio between a parallel word interface and a three-wire serial link made of a bit clock, a frame sync and a data line in each direction. Each frame holds one 32-bit word with the left sample in the upper half. The word is sent as 32 bit-clock slots, 16 for each channel. A single format input chooses standard I2S framing or left-justified framing. Another input chooses whether the engine generates the bit clock from a divider code or follows a bit clock from outside. In both cases the engine drives the frame sync.

Playback and recording can be switched off one at a time. The link stays up while at least one direction is on, and it returns to idle only when both are off. An internal loopback can feed the transmitted bit stream into the receiver in place of the data-in pin, which lets the datapath be tested without anything attached to the pins. Transmit words are offered with a valid flag and taken on a ready strobe once per frame. Received words come out with a one-cycle valid pulse. Both directions always run at the same frame rate.

Top module: `i2s_serial_engine`

## Requirements
- R1: In master mode (`cfg_drive_bclk`=1) the bit clock spends exactly `cfg_div`+1 system clock cycles in each phase, and `bclk_oe` is 1.
- R2: In slave mode (`cfg_drive_bclk`=0), `bclk_oe` is 0 and `bclk_out` stays low. Bit timing follows `bclk_in` after synchronisation, and `fs_out` is still driven.
- R3: A frame has 32 bit-clock slots. Each word goes out MSB first, and bits [31:16] (left) are sent before bits [15:0] (right). A received word is delivered with the same layout.
- R4: With `cfg_framing`=0 (I2S), `fs_out` is low for the left half and high for the right half. Each word's MSB comes one bit clock after the falling edge of `fs_out`.
- R5: With `cfg_framing`=1 (left-justified), `fs_out` is high for the left half and low for the right half. The MSB goes out in the same slot in which `fs_out` rises.
- R6: `sd_out` changes only when the bit clock falls. Received bits are taken when the bit clock rises.
- R7: When `cfg_play_off`=1, `tx_ready` never asserts and `sd_out` is held low.
- R8: When `cfg_rec_off`=1, `rx_valid` never asserts.
- R9: The link runs while either direction is enabled. With both `cfg_play_off` and `cfg_rec_off` at 1, the bit clock stays low, `sd_out` is low, and `fs_out` rests at the right-channel level (high for I2S, low for left-justified).
- R10: With `cfg_loopback`=1, the receiver takes the transmitted stream and ignores `sd_in`. Each word that was sent is then delivered unchanged on `rx_word`.
- R11: If `tx_valid` is low at the start of a frame, that frame transmits an all-zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_framing | input | 1 | 0 = I2S, 1 = left-justified |
| cfg_drive_bclk | input | 1 | 1 = engine generates bit clock, 0 = bit clock from `bclk_in` |
| cfg_play_off | input | 1 | Disables transmission |
| cfg_rec_off | input | 1 | Disables reception |
| cfg_loopback | input | 1 | Routes the transmit stream into the receiver |
| cfg_div | input | DIV_W | Bit-clock half period minus one, in system clocks |
| tx_word | input | 32 | Next stereo word, left in [31:16] |
| tx_valid | input | 1 | `tx_word` holds a word |
| tx_ready | output | 1 | Word taken at the next clock edge |
| rx_word | output | 32 | Last received stereo word |
| rx_valid | output | 1 | One-cycle pulse: `rx_word` is new |
| bclk_in | input | 1 | External bit clock (slave mode) |
| bclk_out | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Output enable for the bit-clock pad |
| fs_out | output | 1 | Frame sync |
| sd_in | input | 1 | Serial data in |
| sd_out | output | 1 | Serial data out |

## Verification
The main transfer is exercised in four setups: master I2S with loopback while `sd_in` is forced high, master left-justified with the data pins wired together externally, slave I2S from an outside bit clock, and runs with one direction switched off. Forcing `sd_in` high separates a real loopback from a receiver that still reads the pin. Switching between the two framings catches a wrong sync polarity or a wrong MSB offset, because an independent decoder on the pins locks onto the sync edge that the selected format calls for. Data patterns with distinct upper and lower halves show whether the channels have been swapped. Frames after the last offered word must decode as zero, and a phase with both directions off shows whether the clocks and sync come to rest.

// File: rtl/i2s_eng_pkg.sv
`timescale 1ns/1ps
package i2s_eng_pkg;
    localparam int SAMPLE_W  = 16;
    localparam int CHANNELS  = 2;
    localparam int WORD_W    = SAMPLE_W * CHANNELS;
    localparam int SLOT_W    = $clog2(WORD_W);
    localparam int HALF_SLOT = WORD_W / 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SLOT_W-1:0] slot_t;

    localparam slot_t LAST_SLOT  = slot_t'(WORD_W - 1);
    localparam slot_t FIRST_SLOT = slot_t'(0);

    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_LJ  = 1'b1
    } framing_e;
endpackage

// File: rtl/i2s_bclk_unit.sv
`timescale 1ns/1ps
module i2s_bclk_unit #(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_en,
    input  logic             drive,
    input  logic [DIV_W-1:0] div,
    input  logic             bclk_in,
    output logic             bclk_q,
    output logic             rise_evt,
    output logic             fall_evt
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [DIV_W-1:0]   cnt;
        logic               bclk;
        logic [CHAIN_W-1:0] sync;
    } bclk_state_t;

    localparam bclk_state_t RESET_STATE = '0;

    bclk_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        rise_evt = 1'b0;
        fall_evt = 1'b0;
        st_d.sync = {st_q.sync[CHAIN_W-2:0], bclk_in};
        if (!link_en) begin
            st_d.cnt  = '0;
            st_d.bclk = 1'b0;
        end else if (drive) begin
            if (st_q.cnt == div) begin
                st_d.cnt  = '0;
                st_d.bclk = ~st_q.bclk;
                rise_evt  = ~st_q.bclk;
                fall_evt  = st_q.bclk;
            end else begin
                st_d.cnt = st_q.cnt + DIV_W'(1);
            end
        end else begin
            st_d.cnt  = '0;
            st_d.bclk = 1'b0;
            rise_evt  = st_q.sync[CHAIN_W-2] & ~st_q.sync[CHAIN_W-1];
            fall_evt  = ~st_q.sync[CHAIN_W-2] & st_q.sync[CHAIN_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    assign bclk_q = st_q.bclk;

    // R1: a generated bit-clock phase ends only when the divider count reaches the code
    p_half_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && drive && $past(link_en && drive) && !$stable(bclk_q))
            |-> ($past(st_q.cnt) == $past(div)));

    // R2: no generated clock in slave mode
    p_slave_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !drive |=> !bclk_q);

    // R9: idle link parks the bit clock low
    p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |=> !bclk_q);
endmodule

// File: rtl/i2s_framer.sv
`timescale 1ns/1ps
module i2s_framer
    import i2s_eng_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  link_en,
    input  logic  lj,
    input  logic  fall_evt,
    output slot_t slot_q,
    output logic  started_q,
    output logic  fs_q,
    output logic  frame_start
);
    typedef struct packed {
        slot_t slot;
        logic  started;
        logic  fs;
    } frm_state_t;

    localparam frm_state_t RESET_STATE = '{slot: LAST_SLOT, started: 1'b0, fs: 1'b1};

    frm_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        frame_start = link_en && fall_evt && (st_q.slot == LAST_SLOT);
        if (!link_en) begin
            st_d.slot    = LAST_SLOT;
            st_d.started = 1'b0;
            st_d.fs      = ~lj;
        end else if (fall_evt) begin
            st_d.slot    = st_q.slot + slot_t'(1);
            st_d.started = 1'b1;
            // upper half of slot range carries the right channel
            st_d.fs      = lj ? ~st_d.slot[SLOT_W-1] : st_d.slot[SLOT_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    assign slot_q    = st_q.slot;
    assign started_q = st_q.started;
    assign fs_q      = st_q.fs;

    // R4: while running, the sync only moves at a channel boundary
    p_fs_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && $past(link_en) && $past(started_q) && (lj == $past(lj)) && !$stable(fs_q))
            |-> (slot_q == FIRST_SLOT || slot_q == slot_t'(HALF_SLOT)));

    // R5: the left-channel sync level depends on the framing
    p_left_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && $past(link_en) && $past(fall_evt) && (lj == $past(lj)) && slot_q == FIRST_SLOT)
            |-> (fs_q == lj));

    // R3: a frame starts only from the last slot
    p_frame_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (slot_q == FIRST_SLOT));
endmodule

// File: rtl/i2s_tx_serializer.sv
`timescale 1ns/1ps
module i2s_tx_serializer
    import i2s_eng_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  link_en,
    input  logic  lj,
    input  logic  play_off,
    input  logic  fall_evt,
    input  logic  frame_start,
    input  word_t tx_word,
    input  logic  tx_valid,
    output logic  tx_ready,
    output logic  sd_q
);
    typedef struct packed {
        word_t sh;
        logic  sd;
    } tx_state_t;

    localparam tx_state_t RESET_STATE = '0;

    tx_state_t st_d, st_q;
    word_t     next_sh;

    always_comb begin
        st_d     = st_q;
        tx_ready = frame_start && !play_off;
        next_sh  = {st_q.sh[WORD_W-2:0], 1'b0};
        if (frame_start) begin
            // an empty offer at frame start sends silence
            next_sh = (tx_ready && tx_valid) ? tx_word : '0;
        end
        if (!link_en) begin
            st_d.sh = '0;
            st_d.sd = 1'b0;
        end else if (fall_evt) begin
            st_d.sh = next_sh;
            if (play_off)  st_d.sd = 1'b0;
            else if (lj)   st_d.sd = next_sh[WORD_W-1];
            else           st_d.sd = st_q.sh[WORD_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    assign sd_q = st_q.sd;

    // R6: the data line moves only on a bit-clock fall
    p_sd_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && $past(link_en) && !$stable(sd_q)) |-> $past(fall_evt));

    // R7: no word is taken while playback is off
    p_no_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        play_off |-> !tx_ready);

    // R7: data line low after a bit slot with playback off
    p_sd_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(play_off) && $past(fall_evt)) |-> !sd_q);
endmodule

// File: rtl/i2s_rx_deserializer.sv
`timescale 1ns/1ps
module i2s_rx_deserializer
    import i2s_eng_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  link_en,
    input  logic  lj,
    input  logic  rec_off,
    input  logic  loopback,
    input  logic  started,
    input  slot_t slot,
    input  logic  rise_evt,
    input  logic  sd_in,
    input  logic  sd_loop,
    output word_t rx_word,
    output logic  rx_valid
);
    localparam int CNT_W = SLOT_W + 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    typedef struct packed {
        word_t            sh;
        logic [CNT_W-1:0] cnt;
        word_t            word;
        logic             valid;
    } rx_state_t;

    localparam rx_state_t RESET_STATE = '0;

    rx_state_t st_d, st_q;
    logic      din;
    logic      word_end;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        din        = loopback ? sd_loop : sd_in;
        // I2S words close one slot later than left-justified ones
        word_end   = lj ? (slot == LAST_SLOT) : (slot == FIRST_SLOT);
        if (!link_en) begin
            st_d.sh  = '0;
            st_d.cnt = '0;
        end else if (rise_evt && started) begin
            st_d.sh  = {st_q.sh[WORD_W-2:0], din};
            st_d.cnt = (st_q.cnt == FULL) ? FULL : st_q.cnt + CNT_W'(1);
            if (word_end && st_d.cnt == FULL && !rec_off) begin
                st_d.word  = st_d.sh;
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    assign rx_word  = st_q.word;
    assign rx_valid = st_q.valid;

    // R8: nothing is delivered while recording is off
    p_rec_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rec_off) |-> !rx_valid);

    // R3: one delivery per frame, never back to back
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R3: the delivered word holds between deliveries
    p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_word));
endmodule

// File: rtl/i2s_serial_engine.sv
`timescale 1ns/1ps
module i2s_serial_engine
    import i2s_eng_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_framing,
    input  logic             cfg_drive_bclk,
    input  logic             cfg_play_off,
    input  logic             cfg_rec_off,
    input  logic             cfg_loopback,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [31:0]      tx_word,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [31:0]      rx_word,
    output logic             rx_valid,
    input  logic             bclk_in,
    output logic             bclk_out,
    output logic             bclk_oe,
    output logic             fs_out,
    input  logic             sd_in,
    output logic             sd_out
);
    framing_e fmt;
    logic     lj;
    logic     link_en;
    logic     rise_evt, fall_evt;
    logic     bclk_q;
    slot_t    slot_q;
    logic     started_q;
    logic     frame_start;
    logic     sd_q;

    assign fmt     = framing_e'(cfg_framing);
    assign lj      = (fmt == FMT_LJ);
    assign link_en = !(cfg_play_off && cfg_rec_off);

    i2s_bclk_unit #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_bclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_en  (link_en),
        .drive    (cfg_drive_bclk),
        .div      (cfg_div),
        .bclk_in  (bclk_in),
        .bclk_q   (bclk_q),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    i2s_framer u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_en     (link_en),
        .lj          (lj),
        .fall_evt    (fall_evt),
        .slot_q      (slot_q),
        .started_q   (started_q),
        .fs_q        (fs_out),
        .frame_start (frame_start)
    );

    i2s_tx_serializer u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_en     (link_en),
        .lj          (lj),
        .play_off    (cfg_play_off),
        .fall_evt    (fall_evt),
        .frame_start (frame_start),
        .tx_word     (tx_word),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .sd_q        (sd_q)
    );

    i2s_rx_deserializer u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_en  (link_en),
        .lj       (lj),
        .rec_off  (cfg_rec_off),
        .loopback (cfg_loopback),
        .started  (started_q),
        .slot     (slot_q),
        .rise_evt (rise_evt),
        .sd_in    (sd_in),
        .sd_loop  (sd_q),
        .rx_word  (rx_word),
        .rx_valid (rx_valid)
    );

    assign bclk_out = bclk_q;
    assign bclk_oe  = cfg_drive_bclk;
    assign sd_out   = sd_q;

    // R6: a bit-clock event is either a rise or a fall, never both
    p_edge_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_evt, fall_evt}));

    // R9: an idle link keeps the data line low
    p_idle_sd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |=> !sd_out);
endmodule

// File: tb/sim_i2s_serial_engine.sv
`timescale 1ns/1ps
module sim_i2s_serial_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_framing = 1'b0;
    logic        cfg_drive_bclk = 1'b1;
    logic        cfg_play_off = 1'b1;
    logic        cfg_rec_off = 1'b1;
    logic        cfg_loopback = 1'b0;
    logic [7:0]  cfg_div = 8'h06;
    logic [31:0] tx_word = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [31:0] rx_word;
    logic        rx_valid;
    logic        bclk_in = 1'b0;
    logic        bclk_out, bclk_oe, fs_out, sd_out;
    logic        force_in_high = 1'b0;
    logic        sd_in;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] exp_rx[$];
    logic [31:0] exp_wire[$];
    string       cur_tag = "R3";

    always #5 clk = ~clk;

    // external data wire, or a stuck-high pin to prove loopback
    assign sd_in = force_in_high ? 1'b1 : sd_out;

    i2s_serial_engine u0 (
        .clk(clk), .rst_n(rst_n), .cfg_framing(cfg_framing),
        .cfg_drive_bclk(cfg_drive_bclk), .cfg_play_off(cfg_play_off),
        .cfg_rec_off(cfg_rec_off), .cfg_loopback(cfg_loopback), .cfg_div(cfg_div),
        .tx_word(tx_word), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_word(rx_word), .rx_valid(rx_valid), .bclk_in(bclk_in),
        .bclk_out(bclk_out), .bclk_oe(bclk_oe), .fs_out(fs_out),
        .sd_in(sd_in), .sd_out(sd_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // external bit clock for slave runs (half period 5 system clocks)
    initial begin
        forever begin
            repeat (5) @(posedge clk);
            #1;
            if (!cfg_drive_bclk) bclk_in = ~bclk_in;
            else                 bclk_in = 1'b0;
        end
    end

    // monitor: received words against the scoreboard
    int rx_cnt = 0;
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            rx_cnt++;
            if (cfg_rec_off) begin
                chk(1'b0, "R8 word delivered while recording off", rx_word, 32'h0);
            end else if (exp_rx.size() != 0) begin
                logic [31:0] e;
                e = exp_rx.pop_front();
                chk(rx_word == e, cur_tag, rx_word, e);
            end else begin
                chk(rx_word == 32'h0, cfg_play_off ? "R7 rx word silent" : "R11 rx silence", rx_word, 32'h0);
            end
        end
    end

    // monitor: independent decoder of the pins
    logic        dec_en = 1'b0;
    logic        dec_prev_clk = 1'b0, dec_prev_fs = 1'b0;
    logic        dec_active = 1'b0, dec_pend = 1'b0;
    logic [31:0] dec_sh = '0;
    int          dec_cnt = 0;
    int          wire_cnt = 0;
    always @(negedge clk) begin
        logic bc;
        bc = cfg_drive_bclk ? bclk_out : bclk_in;
        if (!dec_en) begin
            dec_active = 1'b0;
            dec_pend = 1'b0;
            dec_cnt = 0;
            dec_prev_fs = ~cfg_framing;
        end else if (bc && !dec_prev_clk) begin
            if (dec_active) begin
                dec_sh = {dec_sh[30:0], sd_out};
                dec_cnt++;
                if (dec_cnt == 32) begin
                    dec_active = 1'b0;
                    wire_cnt++;
                    if (exp_wire.size() != 0) begin
                        logic [31:0] e;
                        e = exp_wire.pop_front();
                        chk(dec_sh == e, cfg_framing ? "R5 pin word" : "R4 pin word", dec_sh, e);
                    end else begin
                        chk(dec_sh == 32'h0, cfg_play_off ? "R7 pin silent" : "R11 pin silence", dec_sh, 32'h0);
                    end
                end
            end
            if (dec_pend) begin
                dec_active = 1'b1; dec_sh = {31'h0, sd_out}; dec_cnt = 1; dec_pend = 1'b0;
            end
            if (cfg_framing && !dec_prev_fs && fs_out) begin
                dec_active = 1'b1; dec_sh = {31'h0, sd_out}; dec_cnt = 1;
            end
            if (!cfg_framing && dec_prev_fs && !fs_out) dec_pend = 1'b1;
            dec_prev_fs = fs_out;
        end
        dec_prev_clk = bc;
    end

    // monitor: master clock phase length and data-edge discipline
    logic mclk_chk = 1'b0;
    int   hi_run = 0, hi_bad = 0, sd_bad = 0, ready_seen = 0, idle_bad = 0;
    logic idle_chk = 1'b0;
    logic prev_bclk = 1'b0, prev_sd = 1'b0;
    always @(negedge clk) begin
        if (mclk_chk) begin
            if (bclk_out) hi_run++;
            if (prev_bclk && !bclk_out) begin
                if (hi_run != int'(cfg_div) + 1) hi_bad++;
                hi_run = 0;
            end
            if (sd_out != prev_sd && !(prev_bclk && !bclk_out)) sd_bad++;
        end else begin
            hi_run = 0;
        end
        if (tx_ready) ready_seen++;
        if (idle_chk && (bclk_out || sd_out || tx_ready || rx_valid || fs_out != ~cfg_framing)) idle_bad++;
        prev_bclk = bclk_out;
        prev_sd = sd_out;
    end

    function automatic logic [31:0] pattern(input int seed, input int i);
        logic [15:0] l, r;
        l = 16'(seed * 16'h1F3 + i * 16'h0101) ^ 16'h8000;
        r = ~16'(seed + i * 16'h0777);
        return {l, r};
    endfunction

    // driver: offer words, push each taken one into the scoreboard
    task automatic send_words(input int seed, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            tx_word = pattern(seed, i);
            tx_valid = 1'b1;
            do @(negedge clk); while (!tx_ready);
            exp_wire.push_back(tx_word);
            if (!cfg_rec_off) exp_rx.push_back(tx_word);
        end
        @(posedge clk); #1;
        tx_valid = 1'b0;
    endtask

    task automatic run_phase(input logic lj, input logic drv, input logic loop, input logic stuck,
                             input logic poff, input logic roff, input int seed, input string tag);
        int frame_cyc;
        @(posedge clk); #1;
        cfg_framing = lj; cfg_drive_bclk = drv; cfg_loopback = loop; force_in_high = stuck;
        cur_tag = tag;
        repeat (20) @(posedge clk);
        #1;
        rx_cnt = 0; wire_cnt = 0; hi_bad = 0; sd_bad = 0; ready_seen = 0;
        mclk_chk = drv; dec_en = 1'b1;
        cfg_play_off = poff; cfg_rec_off = roff;
        frame_cyc = drv ? 64 * (int'(cfg_div) + 1) : 320;
        if (!poff) send_words(seed, 6);
        else       repeat (6 * frame_cyc) @(posedge clk);
        repeat (3 * frame_cyc + 60) @(posedge clk);
        #1;
        chk(exp_wire.size() == 0, "R3 all sent words seen on pin", 32'(exp_wire.size()), 32'h0);
        chk(exp_rx.size() == 0, {tag, " all sent words received"}, 32'(exp_rx.size()), 32'h0);
        if (drv) begin
            chk(hi_bad == 0, "R1 bit clock phase length", 32'(hi_bad), 32'h0);
            chk(sd_bad == 0, "R6 data changes only at bit clock fall", 32'(sd_bad), 32'h0);
            chk(bclk_oe == 1'b1, "R1 clock pad enabled", {31'h0, bclk_oe}, 32'h1);
        end else begin
            chk(bclk_oe == 1'b0, "R2 clock pad released", {31'h0, bclk_oe}, 32'h0);
            chk(wire_cnt > 0, "R2 frames follow external clock", 32'(wire_cnt), 32'h1);
        end
        if (poff) begin
            chk(ready_seen == 0, "R7 no word taken", 32'(ready_seen), 32'h0);
            chk(rx_cnt > 0, "R9 link runs with only recording", 32'(rx_cnt), 32'h1);
        end
        if (roff) begin
            chk(rx_cnt == 0, "R8 no word delivered", 32'(rx_cnt), 32'h0);
            chk(wire_cnt > 0, "R9 link runs with only playback", 32'(wire_cnt), 32'h1);
        end
        mclk_chk = 1'b0; dec_en = 1'b0;
        cfg_play_off = 1'b1; cfg_rec_off = 1'b1;
        repeat (60) @(posedge clk);
        #1;
        exp_wire.delete();
        exp_rx.delete();
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(bclk_out == 1'b0, "R9 reset bit clock low", {31'h0, bclk_out}, 32'h0);
        chk(fs_out == 1'b1, "R9 reset sync at I2S right level", {31'h0, fs_out}, 32'h1);
        chk(sd_out == 1'b0, "R9 reset data low", {31'h0, sd_out}, 32'h0);
        chk(rx_valid == 1'b0 && tx_ready == 1'b0, "R9 reset no handshakes", {30'h0, rx_valid, tx_ready}, 32'h0);

        run_phase(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1, "R10 loopback I2S");
        run_phase(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2, "R5 LJ external wire");
        run_phase(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3, "R2 slave I2S");
        run_phase(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4, "R7 playback off");
        run_phase(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 5, "R8 recording off");

        @(posedge clk); #1;
        cfg_framing = 1'b1; cfg_drive_bclk = 1'b1;
        repeat (5) @(posedge clk);
        #1 idle_chk = 1'b1; idle_bad = 0;
        repeat (300) @(posedge clk);
        #1 idle_chk = 1'b0;
        chk(idle_bad == 0, "R9 idle link quiet, sync at LJ right level", 32'(idle_bad), 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule